// File: doc/BRIEF.md
# Programmable-Order CIC Decimator

This block is a cascaded integrator-comb decimator for a stream of 16-bit signed fractional samples that arrive on every input clock. It lowers the sample rate by a factor R from 1 to 1024 and applies a filter of order N from 1 to 5. The integrators run at the input rate. The comb section and the output register run once every R input cycles, under an enable that an internal counter derives from the input clock.

Integrators and combs are 66 bits wide (16 + 5 * 10). That width holds the full gain R^N at the largest settings, so integrator wraparound cancels in the combs. Stages beyond the programmed order are idle, and their position passes the signal through unchanged. The output is the 24 most significant bits of the last comb result. No scaling is applied, so small R or N give small outputs.

A bypass setting skips the filter. The input sample then appears at the top of the output word one cycle later, with a valid flag on every cycle. Rate, order and bypass are taken only around reset and stay fixed until the next reset.

Top module: `cic_decimator`

## Requirements
- R1: While `rst_ni` is low, and after release until the first result, `valid_o` is 0 and `data_o` is 0.
- R2: With a constant input x held since reset, each settled output equals floor(x * R^N / 2^42) as a signed 24-bit value. This is bits 65..42 of the 66-bit result.
- R3: `rate_i` holds R-1 (10 bits), giving R in 1..1024. A new result appears exactly every R input cycles.
- R4: When R > 1, `valid_o` is a single-cycle pulse for each result.
- R5: `stages_i` (3 bits) sets N. The value 0 acts as order 1, values 6 and 7 act as order 5, and unused stages pass data unchanged.
- R6: With `bypass_i` = 1, `data_o` equals {previous cycle's `sample_i`, 8'h00} and `valid_o` is 1 on every cycle.
- R7: `rate_i`, `stages_i` and `bypass_i` are sampled on the first clock edge after `rst_ni` rises. Later changes have no effect until the next reset.
- R8: Integrators wrap modulo 2^66. Outputs stay exact however long the input runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 16 | Two's complement fractional sample, bit 15 is sign |
| rate_i | input | 10 | Decimation factor minus one |
| stages_i | input | 3 | Filter order request |
| bypass_i | input | 1 | Forward input without filtering |
| data_o | output | 24 | Filtered (or forwarded) sample |
| valid_o | output | 1 | High on cycles carrying a new result |

## Verification
The hardest state to reach is the one where the deep integrators have wrapped around their 66-bit range many times while the comb output must still be exact. A full-scale constant needs thousands of input cycles at R = 1024 and order 5 before that happens. The bench holds a constant input from reset through ten decimated outputs at the largest rate and order, including the most negative sample. It compares the settled results with the closed-form DC gain, which is only visible at 24 bits when R^N is large. It also holds constants at orders 1, 4 and the clamped codes 0 and 7 to separate the order decoding.

// File: rtl/cic_pkg.sv
package cic_pkg;

  function automatic int unsigned acc_width(input int unsigned in_w,
                                            input int unsigned n_max,
                                            input int unsigned rate_w);
    return in_w + n_max * rate_w;
  endfunction

  // requested order clamped to 1..n_max
  function automatic int unsigned eff_order(input int unsigned req,
                                            input int unsigned n_max);
    if (req == 0) return 1;
    if (req > n_max) return n_max;
    return req;
  endfunction

endpackage

// File: rtl/cic_rate_div.sv
module cic_rate_div #(
  parameter int RATE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RATE_W-1:0] last_i,
  output logic              tick_o
);

  logic [RATE_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
  end

  // R3: counter never passes the programmed limit
  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i);

  // R3: ticks are spaced when R > 1
  a_r3_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && last_i != '0) |=> !tick_o);

endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 66,
  parameter int N_MAX = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic [N_MAX-1:0]        en_i,
  input  logic [IN_W-1:0]         x_i,
  output logic signed [ACC_W-1:0] y_o
);

  logic signed [ACC_W-1:0] acc_q [N_MAX];
  logic signed [ACC_W-1:0] tap   [N_MAX+1];

  assign tap[0] = {{(ACC_W-IN_W){x_i[IN_W-1]}}, x_i};

  for (genvar k = 0; k < N_MAX; k++) begin : g_int
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 acc_q[k] <= '0;
      else if (run_i && en_i[k])   acc_q[k] <= acc_q[k] + tap[k];  // wraps mod 2^ACC_W
    end
    assign tap[k+1] = en_i[k] ? acc_q[k] : tap[k];

    // R5: an idle integrator holds no state
    a_r5_idle_integ_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[k] |-> acc_q[k] == '0);
  end

  assign y_o = tap[N_MAX];

endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int ACC_W = 66,
  parameter int N_MAX = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic [N_MAX-1:0]        en_i,
  input  logic signed [ACC_W-1:0] d_i,
  output logic signed [ACC_W-1:0] y_o
);

  logic signed [ACC_W-1:0] dly_q [N_MAX];
  logic signed [ACC_W-1:0] stg   [N_MAX+1];

  assign stg[0] = d_i;

  for (genvar k = 0; k < N_MAX; k++) begin : g_comb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                dly_q[k] <= '0;
      else if (tick_i && en_i[k]) dly_q[k] <= stg[k];
    end
    assign stg[k+1] = en_i[k] ? (stg[k] - dly_q[k]) : stg[k];

    // R5: an idle comb delay holds no state
    a_r5_idle_comb_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[k] |-> dly_q[k] == '0);
  end

  assign y_o = stg[N_MAX];

endmodule

// File: rtl/cic_decimator.sv
module cic_decimator #(
  parameter int IN_W   = 16,
  parameter int OUT_W  = 24,
  parameter int N_MAX  = 5,
  parameter int RATE_W = 10,
  parameter int ORD_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IN_W-1:0]   sample_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [ORD_W-1:0]  stages_i,
  input  logic              bypass_i,
  output logic [OUT_W-1:0]  data_o,
  output logic              valid_o
);

  localparam int ACC_W = cic_pkg::acc_width(IN_W, N_MAX, RATE_W);
  localparam int PAD_W = OUT_W - IN_W;

  logic              load_q;
  logic [RATE_W-1:0] rate_q;
  logic [ORD_W-1:0]  ord_q;
  logic              byp_q;
  logic              run;

  // settings captured on the first edge after reset release, frozen after
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b1;
      rate_q <= '0;
      ord_q  <= '0;
      byp_q  <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (load_q) begin
        rate_q <= rate_i;
        ord_q  <= stages_i;
        byp_q  <= bypass_i;
      end
    end
  end

  assign run = !load_q;

  int unsigned ord_n;
  always_comb ord_n = cic_pkg::eff_order(int'(ord_q), N_MAX);

  logic [N_MAX-1:0] stg_en;
  for (genvar k = 0; k < N_MAX; k++) begin : g_en
    assign stg_en[k] = !byp_q && (ord_n > k);
  end

  logic [IN_W-1:0] x_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  x_q <= '0;
    else if (run) x_q <= sample_i;
  end

  logic                    tick;
  logic signed [ACC_W-1:0] int_y;
  logic signed [ACC_W-1:0] comb_y;

  cic_rate_div #(.RATE_W(RATE_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run && !byp_q),
    .last_i (rate_q),
    .tick_o (tick)
  );

  cic_integ_chain #(.IN_W(IN_W), .ACC_W(ACC_W), .N_MAX(N_MAX)) u_int (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .en_i   (stg_en),
    .x_i    (x_q),
    .y_o    (int_y)
  );

  cic_comb_chain #(.ACC_W(ACC_W), .N_MAX(N_MAX)) u_comb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .en_i   (stg_en),
    .d_i    (int_y),
    .y_o    (comb_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else if (!run) begin
      valid_o <= 1'b0;
    end else if (byp_q) begin
      data_o  <= {sample_i, {PAD_W{1'b0}}};
      valid_o <= 1'b1;
    end else begin
      valid_o <= tick;
      if (tick) data_o <= comb_y[ACC_W-1 -: OUT_W];
    end
  end

  // R4: each decimated result is flagged for one cycle only
  a_r4_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !byp_q && rate_q != '0) |=> !valid_o);

  // R4: a divider tick always yields a flagged result
  a_r4_tick_to_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !byp_q) |=> valid_o);

  // R6: bypass streams a result every cycle
  a_r6_bypass_stream: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && byp_q) |=> valid_o);

  // R1: nothing is flagged before the datapath runs
  a_r1_quiet_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |=> !valid_o);

endmodule

// File: tb/cic_decimator_tb_top.sv
`timescale 1ns/1ps
module cic_decimator_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] sample_i = '0;
  logic [9:0]  rate_i = '0;
  logic [2:0]  stages_i = '0;
  logic        bypass_i = 1'b0;
  logic [23:0] data_o;
  logic        valid_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cic_decimator dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .sample_i (sample_i),
    .rate_i   (rate_i),
    .stages_i (stages_i),
    .bypass_i (bypass_i),
    .data_o   (data_o),
    .valid_o  (valid_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_reset(input int rate_m1, input int ord, input bit byp, input int x);
    @(negedge clk);
    rst_ni   = 1'b0;
    rate_i   = 10'(rate_m1);
    stages_i = 3'(ord);
    bypass_i = byp;
    sample_i = 16'(x);
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(valid_o), 0);
    check("R1 data in reset", int'(data_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_valid();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!valid_o && guard < 5000);
  endtask

  task automatic measure_period(output int p);
    wait_valid();
    p = 0;
    do begin
      @(negedge clk);
      p++;
    end while (!valid_o && p < 5000);
  endtask

  task automatic dc_test(input string req, input int rate_m1, input int ord,
                         input int x, input int exp);
    apply_reset(rate_m1, ord, 1'b0, x);
    repeat (7) wait_valid();
    for (int i = 0; i < 3; i++) begin
      wait_valid();
      check(req, $signed(data_o), exp);
    end
  endtask

  task automatic t_reset_quiet();
    apply_reset(1023, 5, 1'b0, 100);
    check("R1 valid after release", int'(valid_o), 0);
    check("R1 data after release", int'(data_o), 0);
  endtask

  task automatic t_rates();
    int p;
    apply_reset(2, 1, 1'b0, 0);
    measure_period(p);
    check("R3 period R=3", p, 3);
    measure_period(p);
    check("R3 period R=3 again", p, 3);
    apply_reset(0, 5, 1'b0, -7);
    measure_period(p);
    check("R3 period R=1", p, 1);
    repeat (10) @(negedge clk);
    check("R2 R=1 gain one", $signed(data_o), -1);
    apply_reset(1023, 2, 1'b0, 0);
    measure_period(p);
    check("R3 period R=1024", p, 1024);
    wait_valid();
    @(negedge clk);
    check("R4 pulse width", int'(valid_o), 0);
  endtask

  task automatic t_bypass();
    logic [15:0] vals [4] = '{16'h7FFF, 16'h8000, 16'h1234, 16'h0000};
    apply_reset(1023, 5, 1'b1, 0);
    repeat (3) @(negedge clk);
    foreach (vals[i]) begin
      sample_i = vals[i];
      @(negedge clk);
      check("R6 bypass data", int'(data_o), int'({vals[i], 8'h00}));
      check("R6 bypass valid", int'(valid_o), 1);
    end
  endtask

  task automatic t_frozen_cfg();
    int p;
    apply_reset(1023, 4, 1'b0, 1000);
    repeat (8) wait_valid();
    rate_i   = 10'd2;
    stages_i = 3'd1;
    bypass_i = 1'b1;
    measure_period(p);
    check("R7 period after change", p, 1024);
    check("R7 data after change", $signed(data_o), 250);
    @(negedge clk);
    check("R7 no bypass after change", int'(valid_o), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_quiet();
    t_rates();
    t_bypass();
    dc_test("R2 R8 N5 x=1000", 1023, 5, 1000, 256000);
    dc_test("R2 R8 N5 x=-32768", 1023, 5, -32768, -8388608);
    dc_test("R5 code 7 as N5", 1023, 7, 4, 1024);
    dc_test("R2 R5 N4 x=-1000", 1023, 4, -1000, -250);
    dc_test("R2 R5 N1 x=-5", 1023, 1, -5, -1);
    dc_test("R5 code 0 as N1", 1023, 0, -3, -1);
    t_frozen_cfg();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule